// File: doc/BRIEF.md
# Privileged Special Register File

This block holds the small set of special registers that a processor core reaches only through privileged get and set operations: the status word, the trap program counter, the trap memory address, a software-owned trap-save word and a counter of memory references. The instruction decoder presents a request with a register index, a direction, write data and a flag that marks a get whose destination is register zero. The block answers one cycle later with read data, with a request to load the program counter, or with a privilege-violation trap.

Trap entry arrives as a separate event. It carries the faulting program counter and, for addressing faults, the faulting virtual address. The block saves these and moves the current privilege level into the saved-level field. A get with destination zero reverses this: it returns the register value as the new program counter and restores the saved level, so reading the trap program counter this way is the return from trap. Memory-reference strobes from the fetch and load/store paths advance the counter.

Top module: `spreg_bank`

## Requirements
- R1: After reset every special register reads as 0, and `rd_valid`, `priv_trap` and `pc_load` are low.
- R2: A get of index 0 (status word), 1 (trap PC), 2 (trap address), 3 (trap-save) or 8 (reference counter) gives `rd_valid` high for one cycle on the next cycle, with `rd_data` equal to the register value before any update made in the request cycle. `rd_data` is 0 whenever `rd_valid` is low.
- R3: Indices 4 to 7 and 9 to 15 read as 0, and a set to them changes no register.
- R4: A get or set made while status bits [15:12] (level) equal 4'b1111 raises `priv_trap` for one cycle on the next cycle and has no other effect: no read, no write, no PC load.
- R5: On `trap_valid`, the trap PC takes `trap_pc`, status bits [11:8] (saved level) take the old level, the level becomes 0, and status bits [7:0] are kept.
- R6: The trap address register takes `trap_addr` only on a trap with `trap_is_mem` high; any other trap leaves it unchanged.
- R7: The counter adds 1 in every cycle with `mem_ref` high, a trap in the same cycle included. A permitted set to index 8 in the same cycle loads the written value instead.
- R8: A permitted get with `acc_dst_zero` high gives `pc_load` high for one cycle on the next cycle with `pc_value` equal to the register value, copies the saved level into the level, and gives no `rd_valid`. `pc_value` is 0 whenever `pc_load` is low.
- R9: Only a set of index 0 or a trap changes status bits [7:0]; all other gets and sets leave the status word unchanged, apart from the level restore of R8.
- R10: A request made in the same cycle as `trap_valid` is dropped: no output pulse and no register write.
- R11: The trap-save register returns the last value written and is changed by nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Get or set request present |
| acc_write | input | 1 | 1 = set, 0 = get |
| acc_idx | input | 4 | Special register index |
| acc_dst_zero | input | 1 | Get targets register zero (PC load with level restore) |
| acc_wdata | input | DATA_W | Data for a set |
| trap_valid | input | 1 | Trap entry this cycle |
| trap_is_mem | input | 1 | Trap caused by a memory address |
| trap_pc | input | DATA_W | Program counter to save on trap |
| trap_addr | input | DATA_W | Faulting virtual address |
| mem_ref | input | 1 | One memory reference (fetch, load or store) this cycle |
| rd_valid | output | 1 | Get result valid |
| rd_data | output | DATA_W | Get result |
| priv_trap | output | 1 | Privilege-violation trap pulse |
| pc_load | output | 1 | Load the program counter |
| pc_value | output | DATA_W | New program counter value |

## Verification
The assertions watch on every cycle that the three output pulses never overlap, that a request at level 4'b1111 yields only the violation trap with the status word held, that trap entry moves the level into the saved field and zeroes it, that the trap address changes only on addressing faults, that the counter advances on each reference, and that requests colliding with a trap produce nothing. The values returned by gets, the PC handed back on a return from trap, the reserved indices reading zero and the precedence of a counter write over a same-cycle reference are shown by the bench, which replays random and directed request streams against its own register model and compares every output.

// File: rtl/spreg_pkg.sv
// Package: shared index map and status-word field positions for the
// special register file. Assumes a status word at least 16 bits wide.
package spreg_pkg;
    localparam int IDX_W    = 4;
    localparam int LVL_W    = 4;
    localparam int LVL_LSB  = 12;
    localparam int OLD_LSB  = 8;
    localparam int KEEP_W   = 8;

    typedef enum logic [IDX_W-1:0] {
        SR_STATUS  = 4'd0,
        SR_TRAP_PC = 4'd1,
        SR_TRAP_AD = 4'd2,
        SR_SAVE    = 4'd3,
        SR_REFCNT  = 4'd8
    } sr_idx_e;

    localparam logic [LVL_W-1:0] LVL_USER = '1;
endpackage

// File: rtl/spreg_gate.sv
// Module: privilege gate. Classifies one request as a permitted get,
// permitted set, return-from-trap or violation. Assumes a request that
// coincides with trap entry is dropped, so it yields nothing.
module spreg_gate
    import spreg_pkg::*;
(
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic             acc_dst_zero,
    input  logic             trap_valid,
    input  logic [LVL_W-1:0] level,
    output logic             viol,
    output logic             do_get,
    output logic             do_set,
    output logic             do_rtt
);
    logic live;

    // Qualify the request and split it by kind.
    always_comb begin
        live   = acc_valid && !trap_valid;
        viol   = live && (level == LVL_USER);
        do_get = live && !viol && !acc_write;
        do_set = live && !viol && acc_write;
        do_rtt = do_get && acc_dst_zero;
    end
endmodule

// File: rtl/spreg_refcnt.sv
// Module: memory-reference counter. Loads on a write, otherwise adds
// one per reference strobe; wraps at the top of its width.
module spreg_refcnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Counter register with write taking precedence over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (inc)
            count <= count + W'(1);
    end
endmodule

// File: rtl/spreg_bank.sv
// Module: privileged special register file (top). Holds the status word,
// trap PC, trap address, trap-save word and reference counter; answers
// gets and sets one cycle later and performs trap entry and return.
// Assumes one request per cycle and DATA_W >= 16.
module spreg_bank
    import spreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [3:0]        acc_idx,
    input  logic              acc_dst_zero,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              trap_valid,
    input  logic              trap_is_mem,
    input  logic [DATA_W-1:0] trap_pc,
    input  logic [DATA_W-1:0] trap_addr,
    input  logic              mem_ref,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              priv_trap,
    output logic              pc_load,
    output logic [DATA_W-1:0] pc_value
);
    localparam int LVL_MSB = LVL_LSB + LVL_W - 1;
    localparam int OLD_MSB = OLD_LSB + LVL_W - 1;

    logic [DATA_W-1:0] status_q, tpc_q, tad_q, save_q, cnt_q;
    logic [DATA_W-1:0] rd_mux;
    logic              viol, do_get, do_set, do_rtt;
    logic              cnt_load;

    spreg_gate u_gate (
        .acc_valid    (acc_valid),
        .acc_write    (acc_write),
        .acc_dst_zero (acc_dst_zero),
        .trap_valid   (trap_valid),
        .level        (status_q[LVL_MSB:LVL_LSB]),
        .viol         (viol),
        .do_get       (do_get),
        .do_set       (do_set),
        .do_rtt       (do_rtt)
    );

    assign cnt_load = do_set && (acc_idx == SR_REFCNT);

    spreg_refcnt #(.W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (acc_wdata),
        .inc      (mem_ref),
        .count    (cnt_q)
    );

    // Read multiplexer: implemented indices return state, others zero.
    always_comb begin
        case (acc_idx)
            SR_STATUS:  rd_mux = status_q;
            SR_TRAP_PC: rd_mux = tpc_q;
            SR_TRAP_AD: rd_mux = tad_q;
            SR_SAVE:    rd_mux = save_q;
            SR_REFCNT:  rd_mux = cnt_q;
            default:    rd_mux = '0;
        endcase
    end

    // Register updates: trap entry, software sets and level restore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            tpc_q    <= '0;
            tad_q    <= '0;
            save_q   <= '0;
        end else if (trap_valid) begin
            tpc_q <= trap_pc;
            if (trap_is_mem)
                tad_q <= trap_addr;
            status_q[OLD_MSB:OLD_LSB] <= status_q[LVL_MSB:LVL_LSB];
            status_q[LVL_MSB:LVL_LSB] <= '0;
        end else if (do_set) begin
            case (acc_idx)
                SR_STATUS:  status_q <= acc_wdata;
                SR_TRAP_PC: tpc_q    <= acc_wdata;
                SR_TRAP_AD: tad_q    <= acc_wdata;
                SR_SAVE:    save_q   <= acc_wdata;
                default:    ;
            endcase
        end else if (do_rtt) begin
            status_q[LVL_MSB:LVL_LSB] <= status_q[OLD_MSB:OLD_LSB];
        end
    end

    // Response registers: one-cycle pulses with data zeroed when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            priv_trap <= 1'b0;
            pc_load   <= 1'b0;
            pc_value  <= '0;
        end else begin
            rd_valid  <= do_get && !acc_dst_zero;
            rd_data   <= (do_get && !acc_dst_zero) ? rd_mux : '0;
            priv_trap <= viol;
            pc_load   <= do_rtt;
            pc_value  <= do_rtt ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/spreg_bank_chk.sv
// Module: property checker for spreg_bank, attached by bind below.
// Observes ports plus the status, trap-address and counter state.
module spreg_bank_chk
    import spreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [3:0]        acc_idx,
    input logic              trap_valid,
    input logic              trap_is_mem,
    input logic [DATA_W-1:0] trap_addr,
    input logic              mem_ref,
    input logic              rd_valid,
    input logic              priv_trap,
    input logic              pc_load,
    input logic [DATA_W-1:0] status_q,
    input logic [DATA_W-1:0] tad_q,
    input logic [DATA_W-1:0] cnt_q
);
    logic at_user, cnt_wr;
    assign at_user = status_q[15:12] == LVL_USER;
    assign cnt_wr  = acc_valid && acc_write && !trap_valid && !at_user
                     && (acc_idx == SR_REFCNT);

    p_excl_pulses_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, priv_trap, pc_load}));

    p_user_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !trap_valid && at_user) |=>
            (priv_trap && !rd_valid && !pc_load && $stable(status_q)));

    p_trap_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> (status_q[15:12] == 4'd0
                        && status_q[11:8] == $past(status_q[15:12])
                        && status_q[7:0] == $past(status_q[7:0])));

    p_tad_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && trap_is_mem) |=> (tad_q == $past(trap_addr)));

    p_tad_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !trap_is_mem) |=> $stable(tad_q));

    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ref && !cnt_wr) |=> (cnt_q == $past(cnt_q) + DATA_W'(1)));

    p_rtt_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (status_q[15:12] == status_q[11:8]));

    p_drop_on_trap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && trap_valid) |=> (!rd_valid && !priv_trap && !pc_load));
endmodule

bind spreg_bank spreg_bank_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_idx     (acc_idx),
    .trap_valid  (trap_valid),
    .trap_is_mem (trap_is_mem),
    .trap_addr   (trap_addr),
    .mem_ref     (mem_ref),
    .rd_valid    (rd_valid),
    .priv_trap   (priv_trap),
    .pc_load     (pc_load),
    .status_q    (status_q),
    .tad_q       (tad_q),
    .cnt_q       (cnt_q)
);

// File: tb/sim_spreg_bank.sv
`timescale 1ns/1ps
// Bench: random and directed request streams checked against a register
// model kept in bench variables.
module sim_spreg_bank;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 0, acc_write = 0, acc_dst_zero = 0;
    logic [3:0]    acc_idx = '0;
    logic [DW-1:0] acc_wdata = '0;
    logic          trap_valid = 0, trap_is_mem = 0, mem_ref = 0;
    logic [DW-1:0] trap_pc = '0, trap_addr = '0;
    logic          rd_valid, priv_trap, pc_load;
    logic [DW-1:0] rd_data, pc_value;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [DW-1:0] m_st, m_tpc, m_tad, m_sav, m_cnt;

    always #10 clk = ~clk;

    spreg_bank #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_idx(acc_idx),
        .acc_dst_zero(acc_dst_zero), .acc_wdata(acc_wdata),
        .trap_valid(trap_valid), .trap_is_mem(trap_is_mem),
        .trap_pc(trap_pc), .trap_addr(trap_addr), .mem_ref(mem_ref),
        .rd_valid(rd_valid), .rd_data(rd_data), .priv_trap(priv_trap),
        .pc_load(pc_load), .pc_value(pc_value)
    );

    function automatic logic [DW-1:0] m_read(input logic [3:0] i);
        case (i)
            4'd0: m_read = m_st;
            4'd1: m_read = m_tpc;
            4'd2: m_read = m_tad;
            4'd3: m_read = m_sav;
            4'd8: m_read = m_cnt;
            default: m_read = '0;
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One request cycle: drive at negedge, update model, check next negedge.
    task automatic step(input logic v, input logic w, input logic [3:0] i,
                        input logic dz, input logic [DW-1:0] wd,
                        input logic tv, input logic tm,
                        input logic [DW-1:0] tp, input logic [DW-1:0] ta,
                        input logic mr, input string tag);
        logic vio, get, set;
        logic [DW-1:0] val;
        logic e_rv, e_pl;
        logic [DW-1:0] e_rd, e_pv;
        acc_valid = v; acc_write = w; acc_idx = i; acc_dst_zero = dz;
        acc_wdata = wd; trap_valid = tv; trap_is_mem = tm;
        trap_pc = tp; trap_addr = ta; mem_ref = mr;
        vio  = v && !tv && (m_st[15:12] == 4'hF);
        get  = v && !tv && !vio && !w;
        set  = v && !tv && !vio && w;
        val  = m_read(i);
        e_rv = get && !dz;
        e_rd = e_rv ? val : '0;
        e_pl = get && dz;
        e_pv = e_pl ? val : '0;
        if (set && i == 4'd8) m_cnt = wd;
        else if (mr) m_cnt = m_cnt + 1;
        if (tv) begin
            m_tpc = tp;
            if (tm) m_tad = ta;
            m_st[11:8]  = m_st[15:12];
            m_st[15:12] = 4'h0;
        end else if (set) begin
            case (i)
                4'd0: m_st  = wd;
                4'd1: m_tpc = wd;
                4'd2: m_tad = wd;
                4'd3: m_sav = wd;
                default: ;
            endcase
        end else if (e_pl) begin
            m_st[15:12] = m_st[11:8];
        end
        @(negedge clk);
        acc_valid = 0; trap_valid = 0; mem_ref = 0;
        check(tag, "rd_valid", DW'(rd_valid), DW'(e_rv));
        check(tag, "rd_data", rd_data, e_rd);
        check(tag, "priv_trap", DW'(priv_trap), DW'(vio));
        check(tag, "pc_load", DW'(pc_load), DW'(e_pl));
        check(tag, "pc_value", pc_value, e_pv);
    endtask

    task automatic get(input logic [3:0] i, input string tag);
        step(1, 0, i, 0, '0, 0, 0, '0, '0, 0, tag);
    endtask

    task automatic set(input logic [3:0] i, input logic [DW-1:0] d, input string tag);
        step(1, 1, i, 0, d, 0, 0, '0, '0, 0, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd2024));
        m_st = '0; m_tpc = '0; m_tad = '0; m_sav = '0; m_cnt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs idle and registers clear after reset
        check("R1", "rd_valid", DW'(rd_valid), '0);
        check("R1", "priv_trap", DW'(priv_trap), '0);
        check("R1", "pc_load", DW'(pc_load), '0);
        get(4'd0, "R1"); get(4'd1, "R1"); get(4'd2, "R1");
        get(4'd3, "R1"); get(4'd8, "R1");
        // R11: trap-save plain read/write
        set(4'd3, 32'hDEAD_BEEF, "R11"); get(4'd3, "R11");
        // R9: status low bits kept across other accesses
        set(4'd0, 32'h0000_300A, "R9");
        set(4'd1, 32'h0000_0777, "R9"); get(4'd2, "R9"); get(4'd0, "R9");
        // R5: trap entry saves PC and moves level
        step(0, 0, 0, 0, '0, 1, 0, 32'h0000_1234, 32'h0000_9999, 0, "R5");
        get(4'd1, "R5"); get(4'd0, "R5");
        // R6: trap address only on addressing faults
        set(4'd2, 32'h0000_0055, "R6");
        step(0, 0, 0, 0, '0, 1, 0, 32'h10, 32'h0000_0AAA, 0, "R6");
        get(4'd2, "R6");
        step(0, 0, 0, 0, '0, 1, 1, 32'h20, 32'h0000_0ABC, 0, "R6");
        get(4'd2, "R6");
        // R7: counter on references, with trap, and write precedence
        for (int k = 0; k < 5; k++) step(0, 0, 0, 0, '0, 0, 0, '0, '0, 1, "R7");
        get(4'd8, "R7");
        step(0, 0, 0, 0, '0, 1, 0, 32'h30, '0, 1, "R7");
        get(4'd8, "R7");
        step(1, 1, 4'd8, 0, 32'h0000_0100, 0, 0, '0, '0, 1, "R7");
        get(4'd8, "R7");
        // R8: return from trap loads PC and restores level
        set(4'd1, 32'h0000_0400, "R8");
        set(4'd0, 32'h0000_0500, "R8");
        step(1, 0, 4'd1, 1, '0, 0, 0, '0, '0, 0, "R8");
        get(4'd0, "R8");
        // R4: user level blocks everything
        set(4'd0, 32'h0000_F000, "R4");
        set(4'd3, 32'h1111_1111, "R4"); get(4'd3, "R4");
        step(1, 0, 4'd1, 1, '0, 0, 0, '0, '0, 0, "R4");
        step(0, 0, 0, 0, '0, 1, 0, 32'h40, '0, 0, "R4");
        get(4'd3, "R4"); get(4'd0, "R4");
        // R3: reserved indices read zero and ignore writes
        set(4'd5, 32'hFFFF_FFFF, "R3"); get(4'd5, "R3");
        set(4'd12, 32'h1234_5678, "R3"); get(4'd12, "R3"); get(4'd15, "R3");
        // R10: request colliding with a trap is dropped
        step(1, 1, 4'd3, 0, 32'h2222_2222, 1, 0, 32'h50, '0, 0, "R10");
        get(4'd3, "R10");
        step(1, 0, 4'd1, 1, '0, 1, 0, 32'h60, '0, 0, "R10");
        // R2: random mix
        for (int n = 0; n < 3000; n++) begin
            logic v, w, dz, tv, tm, mr;
            logic [3:0] i;
            logic [DW-1:0] wd;
            int r;
            string tag;
            r  = $urandom % 100;
            tv = (r < 8);
            v  = ($urandom % 10) < 7;
            w  = $urandom % 2;
            dz = ($urandom % 100) < 15;
            tm = $urandom % 2;
            mr = $urandom % 2;
            case ($urandom % 7)
                0: i = 4'd0; 1: i = 4'd1; 2: i = 4'd2; 3: i = 4'd3;
                4: i = 4'd8; default: i = 4'($urandom);
            endcase
            wd = $urandom;
            if (i == 4'd0 && w)
                wd[15:12] = (($urandom % 4) == 0) ? 4'hF : 4'($urandom % 15);
            if (v && tv) tag = "R10";
            else if (v && m_st[15:12] == 4'hF) tag = "R4";
            else if (v && !w && dz) tag = "R8";
            else if (v && (i inside {[4'd4:4'd7], [4'd9:4'd15]})) tag = "R3";
            else tag = "R2";
            step(v, w, i, dz, wd, tv, tm, $urandom, $urandom, mr, tag);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule